// File: doc/BRIEF.md
# Broadcast-Reference Full-Search SAD Engine

This block finds the best integer motion vector for one block of the current frame by exhaustive search over a 16 x 16 grid of candidate positions in the previous frame. A row of 16 processing elements covers the 16 horizontal offsets at once. The block makes one sweep per vertical offset. Each cycle it reads a single previous-frame pixel and gives that pixel to all 16 elements. Current-block pixels travel along a tapped delay line, so element h receives the current pixel that lies h columns behind the reference pixel. Each element is a three-stage pipeline: subtract, then magnitude, then accumulate.

Both frames sit in external memories. These memories answer in the same cycle, and the block samples their data at the edge that closes the read cycle. An address generator forms every address as a base (the upper-left corner, latched at start) plus a running row/column index. The index sequence is the same for every block. The run-time size code selects the block size: 8x8, 16x16 or 32x32. At the end of each vertical sweep, every element copies its sum into a snapshot register. A serial selector then scans the 16 snapshots while the next sweep is already running. After the last sweep it pulses `done` with the smallest sum and its position.

The sequencer has four states. `ST_IDLE` waits for start. `ST_FETCH` issues one reference read per cycle. `ST_FLUSH` sends a closing boundary marker with no read. `ST_TAIL` waits for the final scan. The transitions are:
- T_LAUNCH: IDLE to FETCH, on start.
- T_SWEEP_END: FETCH to FLUSH, on the last column of the last row of the last offset.
- T_DRAIN: FLUSH to TAIL, always.
- T_REPORT: TAIL to IDLE, on done.

Top module: `bcast_sad_search`

## Requirements
- R1: After reset, `ref_rd`, `cur_rd` and `done` are low, and `mv_h`, `mv_v` and `min_sad` are zero.
- R2: A start pulse sampled in idle latches the size code and both bases. Size code 00 gives N=8, 01 gives N=16, and 10 or 11 gives N=32. The sweep then runs for exactly 16*N*(N+15) consecutive cycles with `ref_rd` high, beginning with the cycle after the sampling edge. Cycle k decomposes into offset v = k/(N*(N+15)), row r, and column c = k mod (N+15), with rows inside an offset and columns inside a row. The reference address in that cycle is ref_base + (v+r)*FRAME_W + c.
- R3: `cur_rd` is high only in sweep cycles with c < N, with cur_base + r*FRAME_W + c on `cur_addr`. Outside the sweep both read strobes are low.
- R4: Each reference pixel read is shared by all 16 elements in that cycle. The sum for position (h,v) is the sum over r,c < N of |ref(v+r, h+c) - cur(r,c)|.
- R5: `done` is a one-cycle pulse. It goes high 16*N*(N+15)+20 clock edges after the edge that sampled start.
- R6: While `done` is high, `min_sad` is the smallest of the 256 sums, and `mv_h`/`mv_v` give its horizontal and vertical offset.
- R7: On equal sums the position with the lowest index v*16+h wins.
- R8: With the default accumulator width of 18 bits, a 32x32 block with every difference at 255 reports 261120 without wrapping.
- R9: A start pulse while a search runs is ignored. Size, bases, read sequence, result and `done` timing stay unchanged.
- R10: `mv_h`, `mv_v` and `min_sad` change only at a `done` pulse and hold their value in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a search when the block is idle |
| blk_size | input | 2 | Block size code (00=8, 01=16, 1x=32) |
| cur_base | input | ADDR_W | Upper-left address of the current block |
| ref_base | input | ADDR_W | Upper-left address of the search window |
| cur_pix | input | PIX_W | Current-frame read data, same cycle |
| ref_pix | input | PIX_W | Previous-frame read data, same cycle |
| cur_rd | output | 1 | Current-frame read strobe |
| cur_addr | output | ADDR_W | Current-frame read address |
| ref_rd | output | 1 | Previous-frame read strobe |
| ref_addr | output | ADDR_W | Previous-frame read address |
| done | output | 1 | Result pulse |
| mv_h | output | 4 | Best horizontal offset |
| mv_v | output | 4 | Best vertical offset |
| min_sad | output | ACC_W | Best sum of absolute differences |

## Verification
The bench compares the complete read sequence every cycle. A design that wrapped a row one column early or late, or that used the wrong block size, would show a wrong address or strobe at once. One test plants an exact copy of the current block at offset (9,5) inside random data. A design with a delay line that is off by one tap would report a non-zero sum or the wrong offset. Fully uniform frames make all 256 sums equal. A selector that replaced on less-or-equal would then report (15,15) instead of (0,0), and the same test at 32x32 with maximal differences exposes an accumulator that wraps. A start pulse with different size and bases, sent in the middle of a search, catches a sequencer that restarts or relatches.

// File: rtl/bsad_pkg.sv
`timescale 1ns/1ps
package bsad_pkg;
    localparam int MAX_DIM = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FLUSH,
        ST_TAIL
    } seq_state_t;

    // Size code to block edge length: 00 -> 8, 01 -> 16, 1x -> 32
    function automatic logic [5:0] blk_dim(input logic [1:0] code);
        case (code)
            2'b00:   return 6'd8;
            2'b01:   return 6'd16;
            default: return 6'd32;
        endcase
    endfunction
endpackage

// File: rtl/bsad_seq.sv
`timescale 1ns/1ps
module bsad_seq
    import bsad_pkg::*;
#(
    parameter int NPOS    = 16,
    parameter int ADDR_W  = 12,
    parameter int FRAME_W = 64,
    localparam int COL_W  = $clog2(MAX_DIM + NPOS),
    localparam int TAG_W  = $clog2(NPOS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        blk_size,
    input  logic [ADDR_W-1:0] cur_base,
    input  logic [ADDR_W-1:0] ref_base,
    input  logic              fin,
    output logic              ref_rd,
    output logic [ADDR_W-1:0] ref_addr,
    output logic              cur_rd,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              mark,
    output logic [TAG_W-1:0]  pass_tag,
    output logic              blk_clr
);
    seq_state_t        state_q, state_nx;
    logic [COL_W-1:0]  dim_q, col_q, row_q;
    logic [TAG_W-1:0]  vpos_q;
    logic [ADDR_W-1:0] cbase_q, rbase_q;
    logic              col_last, row_last, pass_last;

    assign col_last  = (col_q == dim_q + COL_W'(NPOS - 2));
    assign row_last  = (row_q == dim_q - COL_W'(1));
    assign pass_last = (vpos_q == TAG_W'(NPOS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_nx = ST_FETCH;                                 // T_LAUNCH
            ST_FETCH: if (col_last && row_last && pass_last) state_nx = ST_FLUSH;     // T_SWEEP_END
            ST_FLUSH: state_nx = ST_TAIL;                                             // T_DRAIN
            ST_TAIL:  if (fin) state_nx = ST_IDLE;                                    // T_REPORT
        endcase
    end

    // running index and latched bases
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dim_q   <= '0;
            col_q   <= '0;
            row_q   <= '0;
            vpos_q  <= '0;
            cbase_q <= '0;
            rbase_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            dim_q   <= COL_W'(blk_dim(blk_size));
            col_q   <= '0;
            row_q   <= '0;
            vpos_q  <= '0;
            cbase_q <= cur_base;
            rbase_q <= ref_base;
        end else if (state_q == ST_FETCH) begin
            if (col_last) begin
                col_q <= '0;
                if (row_last) begin
                    row_q  <= '0;
                    vpos_q <= vpos_q + TAG_W'(1);
                end else begin
                    row_q <= row_q + COL_W'(1);
                end
            end else begin
                col_q <= col_q + COL_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        ref_rd   = 1'b0;
        cur_rd   = 1'b0;
        ref_addr = '0;
        cur_addr = '0;
        mark     = 1'b0;
        pass_tag = vpos_q;
        blk_clr  = 1'b0;
        unique case (state_q)
            ST_IDLE:  blk_clr = start;
            ST_FETCH: begin
                ref_rd   = 1'b1;
                ref_addr = rbase_q + (ADDR_W'(vpos_q) + ADDR_W'(row_q)) * ADDR_W'(FRAME_W)
                         + ADDR_W'(col_q);
                cur_rd   = (col_q < dim_q);
                if (cur_rd)
                    cur_addr = cbase_q + ADDR_W'(row_q) * ADDR_W'(FRAME_W) + ADDR_W'(col_q);
                mark     = (col_q == '0) && (row_q == '0);
            end
            ST_FLUSH: mark = 1'b1;
            ST_TAIL:  ;
        endcase
    end

    AST_CUR_WITH_REF: assert property (@(posedge clk) disable iff (!rst_n)
        cur_rd |-> ref_rd);                                                         // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rd && !col_last) |=> (ref_rd && ref_addr == $past(ref_addr) + ADDR_W'(1))); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(dim_q) && $stable(rbase_q) && $stable(cbase_q))); // R9
endmodule

// File: rtl/bsad_stagger.sv
`timescale 1ns/1ps
module bsad_stagger #(
    parameter int NPOS  = 16,
    parameter int PIX_W = 8,
    parameter int TAG_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PIX_W-1:0]           ref_pix,
    input  logic [PIX_W-1:0]           cur_pix,
    input  logic                       ref_rd,
    input  logic                       cur_rd,
    input  logic                       mark_in,
    input  logic [TAG_W-1:0]           tag_in,
    output logic [PIX_W-1:0]           ref_q,
    output logic [NPOS-1:0][PIX_W-1:0] cur_taps,
    output logic [NPOS-1:0]            pe_en,
    output logic                       mark_q,
    output logic [TAG_W-1:0]           tag_q
);
    logic [NPOS-1:0] vld_line;
    logic            ref_vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q     <= '0;
            ref_vld_q <= 1'b0;
            mark_q    <= 1'b0;
            tag_q     <= '0;
        end else begin
            ref_q     <= ref_pix;
            ref_vld_q <= ref_rd;
            mark_q    <= mark_in;
            tag_q     <= tag_in;
        end
    end

    // tap h carries the current pixel read h cycles earlier
    for (genvar h = 0; h < NPOS; h++) begin : g_tap
        if (h == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cur_taps[h] <= '0;
                    vld_line[h] <= 1'b0;
                end else begin
                    cur_taps[h] <= cur_pix;
                    vld_line[h] <= cur_rd;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cur_taps[h] <= '0;
                    vld_line[h] <= 1'b0;
                end else begin
                    cur_taps[h] <= cur_taps[h-1];
                    vld_line[h] <= vld_line[h-1];
                end
            end
        end
        assign pe_en[h] = vld_line[h] & ref_vld_q;
    end
endmodule

// File: rtl/bsad_pe.sv
`timescale 1ns/1ps
module bsad_pe #(
    parameter int PIX_W = 8,
    parameter int ACC_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] ref_px,
    input  logic [PIX_W-1:0] cur_px,
    input  logic             en0,
    input  logic             mark2,
    output logic [ACC_W-1:0] acc_snap
);
    logic signed [PIX_W:0] diff_q;
    logic                  en1_q, en2_q;
    logic [PIX_W-1:0]      mag_q;
    logic [ACC_W-1:0]      acc_q, addend;

    // stage 1: subtract; stage 2: magnitude
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diff_q <= '0;
            en1_q  <= 1'b0;
            mag_q  <= '0;
            en2_q  <= 1'b0;
        end else begin
            diff_q <= $signed({1'b0, ref_px}) - $signed({1'b0, cur_px});
            en1_q  <= en0;
            mag_q  <= diff_q[PIX_W] ? PIX_W'(-diff_q) : PIX_W'(diff_q);
            en2_q  <= en1_q;
        end
    end

    assign addend = en2_q ? ACC_W'(mag_q) : '0;

    // stage 3: accumulate; a boundary marker closes the previous sweep
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            acc_snap <= '0;
        end else if (mark2) begin
            acc_snap <= acc_q;
            acc_q    <= addend;
        end else begin
            acc_q    <= acc_q + addend;
        end
    end

    AST_ACC_NOWRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en2_q && !mark2) |=> (acc_q >= $past(acc_q)));                             // R8
endmodule

// File: rtl/bsad_minsel.sv
`timescale 1ns/1ps
module bsad_minsel #(
    parameter int NPOS  = 16,
    parameter int ACC_W = 18,
    localparam int POS_W = $clog2(NPOS),
    localparam int TAG_W = $clog2(NPOS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       mark2,
    input  logic [TAG_W-1:0]           tag2,
    input  logic [NPOS-1:0][ACC_W-1:0] snap,
    output logic                       done,
    output logic [POS_W-1:0]           mv_h,
    output logic [POS_W-1:0]           mv_v,
    output logic [ACC_W-1:0]           min_sad
);
    logic             scan_on, best_ok, last_pass;
    logic [POS_W-1:0] idx, vrow, best_h, best_v;
    logic [ACC_W-1:0] best_sad;
    logic             take;
    logic [ACC_W-1:0] win_sad;
    logic [POS_W-1:0] win_h, win_v;

    // strict less-than keeps the earliest (lowest-index) position on ties
    assign take    = !best_ok || (snap[idx] < best_sad);
    assign win_sad = take ? snap[idx] : best_sad;
    assign win_h   = take ? idx : best_h;
    assign win_v   = take ? vrow : best_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_on   <= 1'b0;
            best_ok   <= 1'b0;
            last_pass <= 1'b0;
            idx       <= '0;
            vrow      <= '0;
            best_h    <= '0;
            best_v    <= '0;
            best_sad  <= '0;
            done      <= 1'b0;
            mv_h      <= '0;
            mv_v      <= '0;
            min_sad   <= '0;
        end else begin
            done <= 1'b0;
            if (clr) begin
                best_ok <= 1'b0;
                scan_on <= 1'b0;
            end else if (mark2 && tag2 != '0) begin
                scan_on   <= 1'b1;
                idx       <= '0;
                vrow      <= POS_W'(tag2 - TAG_W'(1));
                last_pass <= (tag2 == TAG_W'(NPOS));
            end else if (scan_on) begin
                best_sad <= win_sad;
                best_h   <= win_h;
                best_v   <= win_v;
                best_ok  <= 1'b1;
                idx      <= idx + POS_W'(1);
                if (idx == POS_W'(NPOS - 1)) begin
                    scan_on <= 1'b0;
                    if (last_pass) begin
                        done    <= 1'b1;
                        mv_h    <= win_h;
                        mv_v    <= win_v;
                        min_sad <= win_sad;
                    end
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                            // R5
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(min_sad) && $stable(mv_h) && $stable(mv_v)));            // R10
    AST_BEST_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_on && best_ok && !clr && !mark2) |=> (best_sad <= $past(best_sad)));  // R6
    AST_SCAN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mark2 && tag2 != '0) |-> !scan_on);                                        // R4
endmodule

// File: rtl/bcast_sad_search.sv
`timescale 1ns/1ps
module bcast_sad_search #(
    parameter int NPOS    = 16,
    parameter int PIX_W   = 8,
    parameter int ACC_W   = 18,
    parameter int ADDR_W  = 12,
    parameter int FRAME_W = 64,
    localparam int POS_W  = $clog2(NPOS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        blk_size,
    input  logic [ADDR_W-1:0] cur_base,
    input  logic [ADDR_W-1:0] ref_base,
    input  logic [PIX_W-1:0]  cur_pix,
    input  logic [PIX_W-1:0]  ref_pix,
    output logic              cur_rd,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              ref_rd,
    output logic [ADDR_W-1:0] ref_addr,
    output logic              done,
    output logic [POS_W-1:0]  mv_h,
    output logic [POS_W-1:0]  mv_v,
    output logic [ACC_W-1:0]  min_sad
);
    localparam int TAG_W = $clog2(NPOS + 1);

    logic                       mark, blk_clr;
    logic [TAG_W-1:0]           pass_tag;
    logic [PIX_W-1:0]           ref_q;
    logic [NPOS-1:0][PIX_W-1:0] cur_taps;
    logic [NPOS-1:0]            pe_en;
    logic                       mark0, mark1, mark2;
    logic [TAG_W-1:0]           tag0, tag1, tag2;
    logic [NPOS-1:0][ACC_W-1:0] snap_bus;

    bsad_seq #(.NPOS(NPOS), .ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_size(blk_size),
        .cur_base(cur_base), .ref_base(ref_base), .fin(done),
        .ref_rd(ref_rd), .ref_addr(ref_addr), .cur_rd(cur_rd), .cur_addr(cur_addr),
        .mark(mark), .pass_tag(pass_tag), .blk_clr(blk_clr)
    );

    bsad_stagger #(.NPOS(NPOS), .PIX_W(PIX_W), .TAG_W(TAG_W)) u_stagger (
        .clk(clk), .rst_n(rst_n), .ref_pix(ref_pix), .cur_pix(cur_pix),
        .ref_rd(ref_rd), .cur_rd(cur_rd), .mark_in(mark), .tag_in(pass_tag),
        .ref_q(ref_q), .cur_taps(cur_taps), .pe_en(pe_en), .mark_q(mark0), .tag_q(tag0)
    );

    // boundary marker follows the element pipeline to the accumulate stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mark1 <= 1'b0;
            mark2 <= 1'b0;
            tag1  <= '0;
            tag2  <= '0;
        end else begin
            mark1 <= mark0;
            mark2 <= mark1;
            tag1  <= tag0;
            tag2  <= tag1;
        end
    end

    for (genvar h = 0; h < NPOS; h++) begin : g_pe
        bsad_pe #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_pe (
            .clk(clk), .rst_n(rst_n), .ref_px(ref_q), .cur_px(cur_taps[h]),
            .en0(pe_en[h]), .mark2(mark2), .acc_snap(snap_bus[h])
        );
    end

    bsad_minsel #(.NPOS(NPOS), .ACC_W(ACC_W)) u_minsel (
        .clk(clk), .rst_n(rst_n), .clr(blk_clr), .mark2(mark2), .tag2(tag2),
        .snap(snap_bus), .done(done), .mv_h(mv_h), .mv_v(mv_v), .min_sad(min_sad)
    );
endmodule

// File: tb/bcast_sad_search_bench.sv
`timescale 1ns/1ps
module bcast_sad_search_bench;
    localparam int FW = 64;
    localparam int NP = 16;

    logic        clk = 1'b0;
    logic        rst_n, start;
    logic [1:0]  blk_size;
    logic [11:0] cur_base, ref_base, cur_addr, ref_addr;
    logic [7:0]  cur_pix, ref_pix;
    logic        cur_rd, ref_rd, done;
    logic [3:0]  mv_h, mv_v;
    logic [17:0] min_sad;

    logic [7:0] cur_mem [0:4095];
    logic [7:0] ref_mem [0:4095];

    int checks = 0;
    int errors = 0;
    int held_h = 0, held_v = 0, held_sad = 0;

    always #2 clk = ~clk;

    assign cur_pix = cur_mem[cur_addr];
    assign ref_pix = ref_mem[ref_addr];

    bcast_sad_search u_bcast_sad_search (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_size(blk_size),
        .cur_base(cur_base), .ref_base(ref_base), .cur_pix(cur_pix), .ref_pix(ref_pix),
        .cur_rd(cur_rd), .cur_addr(cur_addr), .ref_rd(ref_rd), .ref_addr(ref_addr),
        .done(done), .mv_h(mv_h), .mv_v(mv_v), .min_sad(min_sad)
    );

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // behavioural model of the full search (R4, R6, R7)
    task automatic model(input int n, input int cb, input int rb,
                         output int bh, output int bv, output int bs);
        bs = -1; bh = 0; bv = 0;
        for (int v = 0; v < NP; v++) begin
            for (int h = 0; h < NP; h++) begin
                int s;
                s = 0;
                for (int r = 0; r < n; r++) begin
                    for (int c = 0; c < n; c++) begin
                        int a, b;
                        a = cur_mem[cb + r*FW + c];
                        b = ref_mem[rb + (v+r)*FW + h + c];
                        s += (a > b) ? a - b : b - a;
                    end
                end
                if (bs < 0 || s < bs) begin bs = s; bh = h; bv = v; end
            end
        end
    endtask

    task automatic run_block(input logic [1:0] code, input int cb, input int rb,
                             input int poke_k, input string rq);
        int n, f, dn, eh, ev, es, per;
        n   = (code == 2'b00) ? 8 : (code == 2'b01) ? 16 : 32;
        per = n * (n + 15);
        f   = NP * per;
        dn  = f + 20;
        model(n, cb, rb, eh, ev, es);
        @(negedge clk);
        blk_size = code; cur_base = 12'(cb); ref_base = 12'(rb); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= dn + 2; k++) begin
            if (k < f) begin
                int v, r, c;
                v = k / per;
                r = (k % per) / (n + 15);
                c = k % (n + 15);
                chk("R2", "ref_rd", ref_rd, 1);
                chk("R2", "ref_addr", ref_addr, rb + (v+r)*FW + c);
                chk("R3", "cur_rd", cur_rd, (c < n) ? 1 : 0);
                if (c < n) chk("R3", "cur_addr", cur_addr, cb + r*FW + c);
            end else begin
                chk("R2", "ref_rd idle", ref_rd, 0);
                chk("R3", "cur_rd idle", cur_rd, 0);
            end
            chk("R5", "done", done, (k == dn) ? 1 : 0);
            if (k == dn) begin
                chk(rq, "min_sad", min_sad, es);
                chk(rq, "mv_h", mv_h, eh);
                chk(rq, "mv_v", mv_v, ev);
                held_h = eh; held_v = ev; held_sad = es;
            end else begin
                chk("R10", "min_sad hold", min_sad, held_sad);
                chk("R10", "mv_h hold", mv_h, held_h);
                chk("R10", "mv_v hold", mv_v, held_v);
            end
            // R9: foreign start with other size and bases during the search
            if (k == poke_k) begin
                start = 1'b1; blk_size = ~code; cur_base = 12'h123; ref_base = 12'h321;
            end else if (k == poke_k + 1) begin
                start = 1'b0; blk_size = code; cur_base = 12'(cb); ref_base = 12'(rb);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog R5 actual=timeout expected=finish");
        summary();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; blk_size = 2'b00; cur_base = '0; ref_base = '0;
        for (int i = 0; i < 4096; i++) begin cur_mem[i] = '0; ref_mem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ref_rd", ref_rd, 0);
        chk("R1", "cur_rd", cur_rd, 0);
        chk("R1", "done", done, 0);
        chk("R1", "mv_h", mv_h, 0);
        chk("R1", "mv_v", mv_v, 0);
        chk("R1", "min_sad", min_sad, 0);

        // random frames, 8x8 (R2, R4, R6)
        for (int i = 0; i < 4096; i++) begin
            cur_mem[i] = 8'($urandom); ref_mem[i] = 8'($urandom);
        end
        run_block(2'b00, 130, 70, -1, "R6");

        // planted exact match at h=9, v=5, 16x16 (R4)
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++)
                cur_mem[5*FW + 7 + r*FW + c] = ref_mem[2*FW + 3 + (5+r)*FW + 9 + c];
        run_block(2'b01, 5*FW + 7, 2*FW + 3, -1, "R4");

        // start pulse during a search is ignored, 8x8 (R9)
        run_block(2'b00, 200, 5, 50, "R9");

        // random frames, 32x32 with code 10 (R6)
        run_block(2'b10, 0, 3*FW + 4, -1, "R6");

        // uniform frames: every sum ties, lowest index wins (R7)
        for (int i = 0; i < 4096; i++) begin cur_mem[i] = 8'd10; ref_mem[i] = 8'd20; end
        run_block(2'b00, 0, 0, -1, "R7");

        // maximal differences at 32x32 with code 11 (R8, also R7)
        for (int i = 0; i < 4096; i++) begin cur_mem[i] = 8'd0; ref_mem[i] = 8'd255; end
        run_block(2'b11, 0, 0, -1, "R8");
        chk("R8", "max sum", held_sad, 261120);

        summary();
    end
endmodule